// File: doc/BRIEF.md
# Rolling-Shutter Row and Column Scanner

This block is the digital addressing core of a rolling-shutter image sensor. It has three position pointers: a left row pointer, a right row pointer and a column pointer. Each pointer has its own shift clock and its own active-low home input, and each one moves on the falling edge of its clock. When a pointer steps past the last position of the array, an active-low end flag pulses for one shift period.

The two row pointers run independently. A side-select input picks which one drives the row address. The row read-enable and row-reset strobes reach the array only when that pointer is on a real row. In normal operation one pointer resets rows and the other reads them out some number of row periods later. That gap in row periods is the integration time.

A viewfinder input makes every pointer step by four instead of one. The scan then covers 320 columns by 256 rows of the 1280 x 1024 array.

Top module: `row_scanner`

## Requirements
- R1: While a home input is low at a falling edge of its clock, the pointer is set to position 0 and its end flag reads high. Further falling edges with home held low leave it at 0 and do not advance it.
- R2: A pointer changes only on the falling edge of its own clock. A rising edge leaves its position unchanged.
- R3: With view4 low and home high, each falling edge moves a pointer from position p to p+1 for p below the last position (1279 for columns, 1023 for rows).
- R4: One falling edge after the last position, the position output reads the array size (1280 or 1024) and the end flag reads low. The next falling edge sets the position to the array size plus one and the end flag back to high. The pointer stays parked there until homed.
- R5: With view4 high, each falling edge moves a pointer by four. Column scans visit 320 positions, 0 to 1276. Row scans visit 256 positions, 0 to 1020. The step after the last of these produces the end state of R4.
- R6: The left pointer, the right pointer and the column pointer never move on another pointer's clock or home input.
- R7: row_addr equals left_row when use_left is 1 and right_row when use_left is 0.
- R8: row_sel equals sel_en when the chosen pointer is on a row (position below 1024), and is 0 otherwise.
- R9: row_rst equals rst_en when the chosen pointer is on a row, and is 0 otherwise.
- R10: When both row pointers are clocked together, the difference left_row minus right_row stays constant. This difference is the integration gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| left_clk | input | 1 | Shift clock of the left row pointer (falling edge) |
| left_home_n | input | 1 | Active-low home of the left row pointer |
| right_clk | input | 1 | Shift clock of the right row pointer (falling edge) |
| right_home_n | input | 1 | Active-low home of the right row pointer |
| col_clk | input | 1 | Shift clock of the column pointer (falling edge) |
| col_home_n | input | 1 | Active-low home of the column pointer |
| view4 | input | 1 | 1 = step by four (viewfinder window) |
| use_left | input | 1 | 1 = left pointer drives the row strobes, 0 = right |
| sel_en | input | 1 | Row read-enable request, high active |
| rst_en | input | 1 | Row reset request, high active |
| left_row | output | 11 | Left pointer position |
| right_row | output | 11 | Right pointer position |
| col_pos | output | 11 | Column pointer position |
| left_end_n | output | 1 | Left end-of-scan flag, active low |
| right_end_n | output | 1 | Right end-of-scan flag, active low |
| col_end_n | output | 1 | Column end-of-scan flag, active low |
| row_addr | output | 11 | Position of the chosen row pointer |
| row_sel | output | 1 | Gated row read-enable |
| row_rst | output | 1 | Gated row reset |

## Verification
A wrong step size or a missed home shows on the position outputs after the very next falling shift edge. An end flag that fires at the wrong count, or lasts for more than one shift, shows on the end output after the edge that crosses the last position. A wrong route or wrong gating in the strobe path is combinational, so it is visible as soon as use_left or the pointer changes. A drift between the two row pointers shows as a change in their difference after the first shift in which they are clocked together.

// File: rtl/row_scanner.sv
module row_scanner #(
  parameter int NCOLS = 1280,
  parameter int NROWS = 1024,
  parameter int SKIP  = 4
) (
  input  logic left_clk,
  input  logic left_home_n,
  input  logic right_clk,
  input  logic right_home_n,
  input  logic col_clk,
  input  logic col_home_n,
  input  logic view4,
  input  logic use_left,
  input  logic sel_en,
  input  logic rst_en,
  output logic [$clog2(NROWS+2)-1:0] left_row,
  output logic [$clog2(NROWS+2)-1:0] right_row,
  output logic [$clog2(NCOLS+2)-1:0] col_pos,
  output logic left_end_n,
  output logic right_end_n,
  output logic col_end_n,
  output logic [$clog2(NROWS+2)-1:0] row_addr,
  output logic row_sel,
  output logic row_rst
);
  localparam int RW = $clog2(NROWS+2);
  localparam int CW = $clog2(NCOLS+2);
  localparam logic [RW-1:0] R_END  = RW'(NROWS);
  localparam logic [RW-1:0] R_PARK = RW'(NROWS+1);
  localparam logic [CW-1:0] C_END  = CW'(NCOLS);
  localparam logic [CW-1:0] C_PARK = CW'(NCOLS+1);

  function automatic logic [RW-1:0] row_next(input logic [RW-1:0] cur, input logic sub);
    logic [RW:0] sum;
    sum = {1'b0, cur} + (sub ? (RW+1)'(SKIP) : (RW+1)'(1));
    if (cur >= R_END)                 row_next = R_PARK;
    else if (sum >= (RW+1)'(NROWS))   row_next = R_END;
    else                              row_next = sum[RW-1:0];
  endfunction

  function automatic logic [CW-1:0] col_next(input logic [CW-1:0] cur, input logic sub);
    logic [CW:0] sum;
    sum = {1'b0, cur} + (sub ? (CW+1)'(SKIP) : (CW+1)'(1));
    if (cur >= C_END)                 col_next = C_PARK;
    else if (sum >= (CW+1)'(NCOLS))   col_next = C_END;
    else                              col_next = sum[CW-1:0];
  endfunction

  always_ff @(negedge left_clk)
    if (!left_home_n) left_row <= '0;
    else              left_row <= row_next(left_row, view4);

  always_ff @(negedge right_clk)
    if (!right_home_n) right_row <= '0;
    else               right_row <= row_next(right_row, view4);

  always_ff @(negedge col_clk)
    if (!col_home_n) col_pos <= '0;
    else             col_pos <= col_next(col_pos, view4);

  assign left_end_n  = (left_row  != R_END);
  assign right_end_n = (right_row != R_END);
  assign col_end_n   = (col_pos   != C_END);

  logic on_row;
  assign row_addr = use_left ? left_row : right_row;
  assign on_row   = (row_addr < R_END);
  assign row_sel  = sel_en & on_row;
  assign row_rst  = rst_en & on_row;
endmodule

// File: rtl/row_scanner_chk.sv
module row_scanner_chk #(
  parameter int NCOLS = 1280,
  parameter int NROWS = 1024,
  parameter int SKIP  = 4
) (
  input logic col_clk,
  input logic col_home_n,
  input logic left_clk,
  input logic left_home_n,
  input logic view4,
  input logic use_left,
  input logic [$clog2(NCOLS+2)-1:0] col_pos,
  input logic col_end_n,
  input logic [$clog2(NROWS+2)-1:0] left_row,
  input logic [$clog2(NROWS+2)-1:0] right_row,
  input logic row_sel,
  input logic row_rst
);
  AST_COL_STEP: assert property (@(negedge col_clk) disable iff (!col_home_n)
    (int'(col_pos) < NCOLS-1 && !view4) |=> int'(col_pos) == int'($past(col_pos)) + 1); // R3

  AST_LEFT_STEP: assert property (@(negedge left_clk) disable iff (!left_home_n)
    (int'(left_row) < NROWS-1 && !view4) |=> int'(left_row) == int'($past(left_row)) + 1); // R3

  AST_COL_SKIP: assert property (@(negedge col_clk) disable iff (!col_home_n)
    (int'(col_pos) + SKIP < NCOLS && view4) |=> int'(col_pos) == int'($past(col_pos)) + SKIP); // R5

  AST_COL_END_PULSE: assert property (@(negedge col_clk) disable iff (!col_home_n)
    !col_end_n |=> col_end_n); // R4

  always_comb begin
    AST_ROW_GATE: assert (!(row_sel || row_rst) ||
      int'(use_left ? left_row : right_row) < NROWS); // R8
  end
endmodule

bind row_scanner row_scanner_chk #(.NCOLS(NCOLS), .NROWS(NROWS), .SKIP(SKIP)) u_chk (
  .col_clk(col_clk), .col_home_n(col_home_n), .left_clk(left_clk),
  .left_home_n(left_home_n), .view4(view4), .use_left(use_left),
  .col_pos(col_pos), .col_end_n(col_end_n), .left_row(left_row),
  .right_row(right_row), .row_sel(row_sel), .row_rst(row_rst)
);

// File: tb/row_scanner_tb.sv
module row_scanner_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic left_clk = 0, left_home_n = 0, right_clk = 0, right_home_n = 0;
  logic col_clk = 0, col_home_n = 0, view4 = 0, use_left = 1, sel_en = 0, rst_en = 0;
  logic [10:0] left_row, right_row, col_pos, row_addr;
  logic left_end_n, right_end_n, col_end_n, row_sel, row_rst;

  int checks = 0;
  int errors = 0;

  row_scanner u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit l, input bit r, input bit c);
    @(posedge clk);
    left_clk = l; right_clk = r; col_clk = c;
    @(posedge clk);
    left_clk = 0; right_clk = 0; col_clk = 0;
    @(negedge clk);
  endtask

  // {home_n, view4, expected col_pos, expected col_end_n}
  localparam logic [13:0] VEC [0:9] = '{
    {1'b0, 1'b0, 11'd0,  1'b1},
    {1'b1, 1'b0, 11'd1,  1'b1},
    {1'b1, 1'b0, 11'd2,  1'b1},
    {1'b1, 1'b1, 11'd6,  1'b1},
    {1'b1, 1'b1, 11'd10, 1'b1},
    {1'b1, 1'b0, 11'd11, 1'b1},
    {1'b0, 1'b0, 11'd0,  1'b1},
    {1'b0, 1'b1, 11'd0,  1'b1},
    {1'b1, 1'b1, 11'd4,  1'b1},
    {1'b1, 1'b1, 11'd8,  1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    pulse(1, 1, 1);
    chk("R1 reset left", left_row, 0);
    chk("R1 reset right", right_row, 0);
    chk("R1 reset col", col_pos, 0);
    chk("R1 reset end flags", {left_end_n, right_end_n, col_end_n}, 3'b111);
    left_home_n = 1; right_home_n = 1;

    for (int i = 0; i < 10; i++) begin
      col_home_n = VEC[i][13];
      view4 = VEC[i][12];
      pulse(0, 0, 1);
      chk($sformatf("R1 R3 R5 vector %0d pos", i), col_pos, int'(VEC[i][11:1]));
      chk($sformatf("R1 R3 R5 vector %0d end", i), col_end_n, int'(VEC[i][0]));
    end

    // R2: rising edge alone does nothing
    view4 = 0; col_home_n = 1;
    @(posedge clk); col_clk = 1; @(negedge clk);
    chk("R2 rising edge col", col_pos, 8);
    @(posedge clk); col_clk = 0; @(negedge clk);
    chk("R2 falling edge col", col_pos, 9);

    // R4: full column scan
    col_home_n = 0; pulse(0, 0, 1); col_home_n = 1;
    for (int i = 0; i < 1279; i++) pulse(0, 0, 1);
    chk("R4 last col", col_pos, 1279);
    chk("R4 last col flag", col_end_n, 1);
    pulse(0, 0, 1);
    chk("R4 col end pos", col_pos, 1280);
    chk("R4 col end flag", col_end_n, 0);
    pulse(0, 0, 1);
    chk("R4 col park", col_pos, 1281);
    chk("R4 col park flag", col_end_n, 1);
    pulse(0, 0, 1);
    chk("R4 col stays parked", col_pos, 1281);

    // R4: right rows normal
    right_home_n = 0; pulse(0, 1, 0); right_home_n = 1;
    for (int i = 0; i < 1023; i++) pulse(0, 1, 0);
    chk("R4 last row", right_row, 1023);
    pulse(0, 1, 0);
    chk("R4 row end", right_row, 1024);
    chk("R4 row end flag", right_end_n, 0);
    chk("R6 left untouched by right", left_row, 0);

    // R5: subsampled left rows
    view4 = 1;
    left_home_n = 0; pulse(1, 0, 0); left_home_n = 1;
    for (int i = 0; i < 255; i++) pulse(1, 0, 0);
    chk("R5 last sub row", left_row, 1020);
    chk("R5 last sub row flag", left_end_n, 1);
    pulse(1, 0, 0);
    chk("R5 sub row end", left_row, 1024);
    chk("R5 sub row end flag", left_end_n, 0);
    chk("R6 right untouched by left", right_row, 1024);

    // R5: subsampled columns
    col_home_n = 0; pulse(0, 0, 1); col_home_n = 1;
    for (int i = 0; i < 319; i++) pulse(0, 0, 1);
    chk("R5 last sub col", col_pos, 1276);
    pulse(0, 0, 1);
    chk("R5 sub col end flag", col_end_n, 0);
    view4 = 0;

    // R7 R8 R9: routing and gating
    left_home_n = 0; pulse(1, 0, 0); left_home_n = 1;
    pulse(1, 0, 0); pulse(1, 0, 0);
    use_left = 1; sel_en = 1; rst_en = 1; #1;
    chk("R7 left route", row_addr, 2);
    chk("R8 sel on row", row_sel, 1);
    chk("R9 rst on row", row_rst, 1);
    use_left = 0; #1;
    chk("R7 right route", row_addr, 1024);
    chk("R8 sel gated off row", row_sel, 0);
    chk("R9 rst gated off row", row_rst, 0);
    use_left = 1; sel_en = 0; #1;
    chk("R8 sel follows request", row_sel, 0);
    chk("R9 rst independent of sel", row_rst, 1);
    rst_en = 0; #1;
    chk("R9 rst follows request", row_rst, 0);

    // R10: integration gap held constant
    left_home_n = 0; right_home_n = 0; pulse(1, 1, 0);
    left_home_n = 1; right_home_n = 1;
    for (int i = 0; i < 7; i++) pulse(1, 0, 0);
    chk("R6 right holds while left shifts", right_row, 0);
    for (int i = 0; i < 100; i++) begin
      pulse(1, 1, 0);
      if (i % 25 == 0) chk("R10 gap", int'(left_row) - int'(right_row), 7);
    end
    chk("R10 gap final", int'(left_row) - int'(right_row), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule